// File: doc/BRIEF.md
# Rotating Register Loop Controller

This block carries the control state for modulo-scheduled counted loops. It holds a trip counter, a drain counter and two rotation offsets. One offset renames a window of rotating general registers and the other renames the rotating predicate window. Each time the loop-closing branch executes, the block decides from the two counters whether the branch is taken. It also moves both rotation offsets down by one and reports the value to write into the first stage predicate. Because of this, the fill, steady-state and drain phases of a software-pipelined loop can all run from one loop body.

The rename side is purely combinational. A logical general-register index and a logical predicate index go in, and their physical indices under the current offsets come out. The branch side reports the stage predicate as a write strobe, a value and the physical slot that logical predicate 16 occupies after the rotation. Software loads the counters and the offsets through write strobes.

Top module: `rot_loop_ctl`

## Requirements
- R1: After reset, the trip count, the drain count and both rotation offsets are zero, and `br_taken` and `stage_pred_we` are low.
- R2: When a branch arrives and the trip count is nonzero, `br_taken` is 1 and `stage_pred_val` is 1. The trip count goes down by one and the drain count is left as it was.
- R3: When a branch arrives, the trip count is zero and the drain count is greater than 1, `br_taken` is 1 and `stage_pred_val` is 0. The drain count goes down by one.
- R4: When a branch arrives, the trip count is zero and the drain count is 1 or 0, `br_taken` is 0 and `stage_pred_val` is 0. A drain count of 1 becomes 0, and a drain count of 0 stays at 0.
- R5: Every branch lowers both rotation offsets by one. The general offset wraps from 0 to NUM_GR_ROT-1 and the predicate offset wraps from 0 to 47.
- R6: A logical general index L with 32 <= L < 32+NUM_GR_ROT maps to the physical index 32 + ((L-32+gbase) mod NUM_GR_ROT). Any other index maps to itself.
- R7: A logical predicate index L with 16 <= L <= 63 maps to the physical index 16 + ((L-16+pbase) mod 48). Indices 0 to 15 map to themselves.
- R8: On a branch, `stage_pred_we` is 1, and `stage_pred_pidx` is the physical slot of logical predicate 16 under the predicate offset the branch leaves behind.
- R9: In a cycle that has both a write and a branch, each written register takes the written value and the branch does not change it. The registers that are not written still follow the branch.
- R10: In a cycle with no branch and no write, all four registers hold their values, and `br_taken` and `stage_pred_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Loop-closing branch executes this cycle |
| wr_lc_en | input | 1 | Load the trip count |
| wr_lc_val | input | LC_W | Trip count value to load |
| wr_ec_en | input | 1 | Load the drain count |
| wr_ec_val | input | EC_W | Drain count value to load |
| wr_base_en | input | 1 | Load both rotation offsets |
| wr_gr_base | input | clog2(NUM_GR_ROT) | General rotation offset to load |
| wr_pr_base | input | 6 | Predicate rotation offset to load (0..47) |
| gr_lidx | input | 7 | Logical general-register index |
| pr_lidx | input | 6 | Logical predicate index |
| br_taken | output | 1 | Branch goes back to the loop top |
| stage_pred_we | output | 1 | Stage predicate write strobe |
| stage_pred_val | output | 1 | Value for the stage predicate |
| stage_pred_pidx | output | 6 | Physical slot of the stage predicate after rotation |
| gr_pidx | output | 7 | Physical general-register index |
| pr_pidx | output | 6 | Physical predicate index |
| lc_q | output | LC_W | Current trip count |
| ec_q | output | EC_W | Current drain count |
| gr_base_q | output | clog2(NUM_GR_ROT) | Current general rotation offset |
| pr_base_q | output | 6 | Current predicate rotation offset |

## Verification
The bench targets the boundary between draining and exiting. A drain count of 2 must still be taken, and a count of 1 must fall through and clear to 0; a design that compares against the wrong threshold runs one iteration too many or too few. It also checks that a drain count of 0 with a zero trip count stays at 0 and does not wrap to all ones. Both rotation offsets are forced through zero to catch a wrap to the wrong value or a missing modulus in the predicate window, whose size is not a power of two. It then runs a complete loop and confirms that the number of taken branches equals the trip count plus the drain count minus one. A write that collides with a branch must win, and the registers that are not written must still move.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
   typedef enum logic [1:0] {
      RLC_KERNEL = 2'd0,
      RLC_DRAIN  = 2'd1,
      RLC_EXIT   = 2'd2
   } rlc_phase_e;

   localparam int RLC_GR_FIRST = 32;
   localparam int RLC_PR_FIRST = 16;
   localparam int RLC_PR_SIZE  = 48;
   localparam int RLC_GR_IDX_W = 7;
   localparam int RLC_PR_IDX_W = 6;
endpackage

// File: rtl/rlc_count_unit.sv
module rlc_count_unit
   import rlc_pkg::*;
#(
   parameter int LC_W = 8,
   parameter int EC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_valid,
   input  logic            wr_lc_en,
   input  logic [LC_W-1:0] wr_lc_val,
   input  logic            wr_ec_en,
   input  logic [EC_W-1:0] wr_ec_val,
   output logic [LC_W-1:0] lc_q,
   output logic [EC_W-1:0] ec_q,
   output logic            taken,
   output logic            stage_bit
);
   rlc_phase_e      phase;
   logic [LC_W-1:0] lc_nx;
   logic [EC_W-1:0] ec_nx;

   always_comb begin
      if (lc_q != '0)
         phase = RLC_KERNEL;
      else if (ec_q > EC_W'(1))
         phase = RLC_DRAIN;
      else
         phase = RLC_EXIT;
      taken     = br_valid && (phase != RLC_EXIT);
      stage_bit = (phase == RLC_KERNEL);
   end

   always_comb begin
      lc_nx = lc_q;
      ec_nx = ec_q;
      if (br_valid) begin
         if (phase == RLC_KERNEL)
            lc_nx = lc_q - LC_W'(1);
         else if (ec_q != '0)
            ec_nx = ec_q - EC_W'(1);
      end
      if (wr_lc_en) lc_nx = wr_lc_val;
      if (wr_ec_en) ec_nx = wr_ec_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lc_q <= '0;
         ec_q <= '0;
      end else begin
         lc_q <= lc_nx;
         ec_q <= ec_nx;
      end
   end
endmodule

// File: rtl/rlc_rot_base.sv
module rlc_rot_base #(
   parameter int SIZE = 32,
   parameter int W    = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rotate,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] base_q,
   output logic [W-1:0] base_nx
);
   localparam logic [W-1:0] TOP = W'(SIZE - 1);

   always_comb begin
      if (wr_en)
         base_nx = wr_val;
      else if (rotate)
         base_nx = (base_q == '0) ? TOP : base_q - W'(1);
      else
         base_nx = base_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_nx;
   end
endmodule

// File: rtl/rlc_rename.sv
module rlc_rename #(
   parameter int FIRST  = 32,
   parameter int SIZE   = 32,
   parameter int IDX_W  = 7,
   parameter int BASE_W = 5
) (
   input  logic [IDX_W-1:0]  lidx,
   input  logic [BASE_W-1:0] base,
   output logic [IDX_W-1:0]  pidx
);
   localparam int XW = IDX_W + 1;
   localparam logic [XW-1:0] LO = XW'(FIRST);
   localparam logic [XW-1:0] HI = XW'(FIRST + SIZE);
   localparam logic [XW-1:0] SZ = XW'(SIZE);
   localparam bit POW2 = ((SIZE & (SIZE - 1)) == 0);

   logic [XW-1:0] ext, off, sum, wrapped, phys;
   logic          in_reg;

   always_comb begin
      ext    = {1'b0, lidx};
      in_reg = (ext >= LO) && (ext < HI);
      off    = ext - LO;
      sum    = off + XW'(base);
   end

   generate
      if (POW2) begin : g_mask
         localparam int SW = $clog2(SIZE);
         assign wrapped = XW'(sum[SW-1:0]);
      end else begin : g_cmp
         assign wrapped = (sum >= SZ) ? sum - SZ : sum;
      end
   endgenerate

   always_comb begin
      phys = wrapped + LO;
      pidx = in_reg ? phys[IDX_W-1:0] : lidx;
   end
endmodule

// File: rtl/rot_loop_ctl.sv
module rot_loop_ctl
   import rlc_pkg::*;
#(
   parameter int LC_W       = 8,
   parameter int EC_W       = 6,
   parameter int NUM_GR_ROT = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          br_valid,
   input  logic                          wr_lc_en,
   input  logic [LC_W-1:0]               wr_lc_val,
   input  logic                          wr_ec_en,
   input  logic [EC_W-1:0]               wr_ec_val,
   input  logic                          wr_base_en,
   input  logic [$clog2(NUM_GR_ROT)-1:0] wr_gr_base,
   input  logic [5:0]                    wr_pr_base,
   input  logic [6:0]                    gr_lidx,
   input  logic [5:0]                    pr_lidx,
   output logic                          br_taken,
   output logic                          stage_pred_we,
   output logic                          stage_pred_val,
   output logic [5:0]                    stage_pred_pidx,
   output logic [6:0]                    gr_pidx,
   output logic [5:0]                    pr_pidx,
   output logic [LC_W-1:0]               lc_q,
   output logic [EC_W-1:0]               ec_q,
   output logic [$clog2(NUM_GR_ROT)-1:0] gr_base_q,
   output logic [5:0]                    pr_base_q
);
   localparam int GB_W = $clog2(NUM_GR_ROT);
   localparam int PB_W = 6;

   generate
      if (NUM_GR_ROT < 8 || NUM_GR_ROT > 96 || (NUM_GR_ROT % 8) != 0) begin : g_bad_gr
         $error("NUM_GR_ROT must be a multiple of 8 in 8..96");
      end
      if (LC_W < 1 || EC_W < 2) begin : g_bad_cnt
         $error("counter widths too small");
      end
   endgenerate

   logic [GB_W-1:0] gr_base_nx;
   logic [PB_W-1:0] pr_base_nx;
   logic            stage_bit;

   rlc_count_unit #(.LC_W(LC_W), .EC_W(EC_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .br_valid  (br_valid),
      .wr_lc_en  (wr_lc_en),
      .wr_lc_val (wr_lc_val),
      .wr_ec_en  (wr_ec_en),
      .wr_ec_val (wr_ec_val),
      .lc_q      (lc_q),
      .ec_q      (ec_q),
      .taken     (br_taken),
      .stage_bit (stage_bit)
   );

   rlc_rot_base #(.SIZE(NUM_GR_ROT), .W(GB_W)) u_gbase (
      .clk     (clk),
      .rst_n   (rst_n),
      .rotate  (br_valid),
      .wr_en   (wr_base_en),
      .wr_val  (wr_gr_base),
      .base_q  (gr_base_q),
      .base_nx (gr_base_nx)
   );

   rlc_rot_base #(.SIZE(RLC_PR_SIZE), .W(PB_W)) u_pbase (
      .clk     (clk),
      .rst_n   (rst_n),
      .rotate  (br_valid),
      .wr_en   (wr_base_en),
      .wr_val  (wr_pr_base),
      .base_q  (pr_base_q),
      .base_nx (pr_base_nx)
   );

   rlc_rename #(.FIRST(RLC_GR_FIRST), .SIZE(NUM_GR_ROT),
                .IDX_W(RLC_GR_IDX_W), .BASE_W(GB_W)) u_gr_map (
      .lidx (gr_lidx),
      .base (gr_base_q),
      .pidx (gr_pidx)
   );

   rlc_rename #(.FIRST(RLC_PR_FIRST), .SIZE(RLC_PR_SIZE),
                .IDX_W(RLC_PR_IDX_W), .BASE_W(PB_W)) u_pr_map (
      .lidx (pr_lidx),
      .base (pr_base_q),
      .pidx (pr_pidx)
   );

   // slot of logical predicate 16 once this cycle's rotation has landed
   rlc_rename #(.FIRST(RLC_PR_FIRST), .SIZE(RLC_PR_SIZE),
                .IDX_W(RLC_PR_IDX_W), .BASE_W(PB_W)) u_stage_map (
      .lidx (6'(RLC_PR_FIRST)),
      .base (pr_base_nx),
      .pidx (stage_pred_pidx)
   );

   assign stage_pred_we  = br_valid;
   assign stage_pred_val = br_valid && stage_bit;
endmodule

// File: rtl/rlc_chk.sv
module rlc_chk #(
   parameter int LC_W       = 8,
   parameter int EC_W       = 6,
   parameter int NUM_GR_ROT = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          br_valid,
   input logic                          wr_lc_en,
   input logic [LC_W-1:0]               wr_lc_val,
   input logic                          wr_ec_en,
   input logic                          wr_base_en,
   input logic [LC_W-1:0]               lc_q,
   input logic [EC_W-1:0]               ec_q,
   input logic [$clog2(NUM_GR_ROT)-1:0] gr_base_q,
   input logic                          br_taken
);
   localparam int GB_W = $clog2(NUM_GR_ROT);

   // R2
   lc_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !wr_lc_en && lc_q != '0) |=> (lc_q == LC_W'($past(lc_q) - LC_W'(1))));

   // R3
   ec_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !wr_ec_en && lc_q == '0 && ec_q != '0) |=> (ec_q == EC_W'($past(ec_q) - EC_W'(1))));

   // R4
   exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && lc_q == '0 && ec_q <= EC_W'(1)) |-> !br_taken);

   // R5
   gr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !wr_base_en && gr_base_q == '0) |=> (gr_base_q == GB_W'(NUM_GR_ROT - 1)));

   // R9
   lc_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lc_en |=> (lc_q == $past(wr_lc_val)));

   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !wr_lc_en && !wr_ec_en && !wr_base_en) |=>
         ($stable(lc_q) && $stable(ec_q) && $stable(gr_base_q)));
endmodule

bind rot_loop_ctl rlc_chk #(.LC_W(LC_W), .EC_W(EC_W), .NUM_GR_ROT(NUM_GR_ROT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .br_valid   (br_valid),
   .wr_lc_en   (wr_lc_en),
   .wr_lc_val  (wr_lc_val),
   .wr_ec_en   (wr_ec_en),
   .wr_base_en (wr_base_en),
   .lc_q       (lc_q),
   .ec_q       (ec_q),
   .gr_base_q  (gr_base_q),
   .br_taken   (br_taken)
);

// File: tb/sim_rot_loop_ctl.sv
module sim_rot_loop_ctl;
   localparam int LC_W = 8;
   localparam int EC_W = 6;
   localparam int NGR  = 32;
   localparam int GB_W = $clog2(NGR);
   localparam int NV   = 8;

   // vector table: initial LC, EC -> taken, stage value, LC after, EC after
   localparam int T_LC  [NV] = '{5, 1, 255, 0, 0, 0, 0, 0};
   localparam int T_EC  [NV] = '{3, 0, 63, 5, 2, 1, 0, 63};
   localparam int T_TK  [NV] = '{1, 1, 1, 1, 1, 0, 0, 1};
   localparam int T_P16 [NV] = '{1, 1, 1, 0, 0, 0, 0, 0};
   localparam int T_LCN [NV] = '{4, 0, 254, 0, 0, 0, 0, 0};
   localparam int T_ECN [NV] = '{3, 0, 63, 4, 1, 0, 0, 62};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic br_valid = 1'b0;
   logic wr_lc_en = 1'b0;
   logic [LC_W-1:0] wr_lc_val = '0;
   logic wr_ec_en = 1'b0;
   logic [EC_W-1:0] wr_ec_val = '0;
   logic wr_base_en = 1'b0;
   logic [GB_W-1:0] wr_gr_base = '0;
   logic [5:0] wr_pr_base = '0;
   logic [6:0] gr_lidx = '0;
   logic [5:0] pr_lidx = '0;
   logic br_taken, stage_pred_we, stage_pred_val;
   logic [5:0] stage_pred_pidx, pr_pidx, pr_base_q;
   logic [6:0] gr_pidx;
   logic [LC_W-1:0] lc_q;
   logic [EC_W-1:0] ec_q;
   logic [GB_W-1:0] gr_base_q;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rot_loop_ctl #(.LC_W(LC_W), .EC_W(EC_W), .NUM_GR_ROT(NGR)) u0 (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid),
      .wr_lc_en(wr_lc_en), .wr_lc_val(wr_lc_val),
      .wr_ec_en(wr_ec_en), .wr_ec_val(wr_ec_val),
      .wr_base_en(wr_base_en), .wr_gr_base(wr_gr_base), .wr_pr_base(wr_pr_base),
      .gr_lidx(gr_lidx), .pr_lidx(pr_lidx),
      .br_taken(br_taken), .stage_pred_we(stage_pred_we),
      .stage_pred_val(stage_pred_val), .stage_pred_pidx(stage_pred_pidx),
      .gr_pidx(gr_pidx), .pr_pidx(pr_pidx),
      .lc_q(lc_q), .ec_q(ec_q), .gr_base_q(gr_base_q), .pr_base_q(pr_base_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic load(input int lc, input int ec, input int gb, input int pb);
      wr_lc_en = 1; wr_lc_val = LC_W'(lc);
      wr_ec_en = 1; wr_ec_val = EC_W'(ec);
      wr_base_en = 1; wr_gr_base = GB_W'(gb); wr_pr_base = 6'(pb);
      @(posedge clk); @(negedge clk);
      wr_lc_en = 0; wr_ec_en = 0; wr_base_en = 0;
   endtask

   task automatic branch();
      br_valid = 1;
      @(posedge clk); @(negedge clk);
      br_valid = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int taken_cnt;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 lc", int'(lc_q), 0);
      chk("R1 ec", int'(ec_q), 0);
      chk("R1 gbase", int'(gr_base_q), 0);
      chk("R1 pbase", int'(pr_base_q), 0);
      chk("R1 taken", int'(br_taken), 0);
      chk("R1 we", int'(stage_pred_we), 0);
      rst_n = 1;
      @(negedge clk);

      // R2 R3 R4 vector table
      for (int i = 0; i < NV; i++) begin
         load(T_LC[i], T_EC[i], 10, 10);
         br_valid = 1;
         #1;
         chk("R2/R3/R4 taken", int'(br_taken), T_TK[i]);
         chk("R2/R3/R4 stage", int'(stage_pred_val), T_P16[i]);
         chk("R8 we", int'(stage_pred_we), 1);
         chk("R8 pidx", int'(stage_pred_pidx), 16 + 9);
         @(posedge clk); @(negedge clk);
         br_valid = 0;
         chk("R2/R3/R4 lc", int'(lc_q), T_LCN[i]);
         chk("R2/R3/R4 ec", int'(ec_q), T_ECN[i]);
         chk("R5 gbase", int'(gr_base_q), 9);
         chk("R5 pbase", int'(pr_base_q), 9);
      end

      // R5 wrap, R8 slot after wrap
      load(3, 3, 0, 0);
      br_valid = 1;
      #1;
      chk("R8 pidx wrap", int'(stage_pred_pidx), 63);
      @(posedge clk); @(negedge clk);
      br_valid = 0;
      chk("R5 gbase wrap", int'(gr_base_q), NGR - 1);
      chk("R5 pbase wrap", int'(pr_base_q), 47);

      // R6 general rename
      load(0, 0, 5, 47);
      gr_lidx = 7'd32; #1; chk("R6 r32", int'(gr_pidx), 37);
      gr_lidx = 7'd63; #1; chk("R6 r63", int'(gr_pidx), 36);
      gr_lidx = 7'd31; #1; chk("R6 r31", int'(gr_pidx), 31);
      gr_lidx = 7'd64; #1; chk("R6 r64", int'(gr_pidx), 64);
      // R7 predicate rename
      pr_lidx = 6'd17; #1; chk("R7 p17", int'(pr_pidx), 16);
      pr_lidx = 6'd63; #1; chk("R7 p63", int'(pr_pidx), 62);
      pr_lidx = 6'd16; #1; chk("R7 p16", int'(pr_pidx), 63);
      pr_lidx = 6'd5;  #1; chk("R7 p5", int'(pr_pidx), 5);

      // R9 write wins over a branch
      load(5, 3, 20, 20);
      br_valid = 1; wr_lc_en = 1; wr_lc_val = 8'd9;
      @(posedge clk); @(negedge clk);
      br_valid = 0; wr_lc_en = 0;
      chk("R9 lc written", int'(lc_q), 9);
      chk("R9 ec untouched", int'(ec_q), 3);
      chk("R9 gbase follows", int'(gr_base_q), 19);
      br_valid = 1; wr_base_en = 1; wr_gr_base = 5'd7; wr_pr_base = 6'd30;
      @(posedge clk); @(negedge clk);
      br_valid = 0; wr_base_en = 0;
      chk("R9 gbase written", int'(gr_base_q), 7);
      chk("R9 pbase written", int'(pr_base_q), 30);
      chk("R9 lc follows", int'(lc_q), 8);

      // R10 idle holds
      repeat (3) @(negedge clk);
      chk("R10 lc", int'(lc_q), 8);
      chk("R10 ec", int'(ec_q), 3);
      chk("R10 gbase", int'(gr_base_q), 7);
      chk("R10 taken", int'(br_taken), 0);
      chk("R10 we", int'(stage_pred_we), 0);

      // R2 R3 R4 R5 full loop: LC=2, EC=3 gives 4 taken then exit
      load(2, 3, 0, 0);
      taken_cnt = 0;
      for (int k = 0; k < 5; k++) begin
         br_valid = 1;
         #1;
         if (br_taken) taken_cnt++;
         if (k == 4) chk("R4 last not taken", int'(br_taken), 0);
         @(posedge clk); @(negedge clk);
         br_valid = 0;
      end
      chk("R3 taken count", taken_cnt, 4);
      chk("R4 lc end", int'(lc_q), 0);
      chk("R4 ec end", int'(ec_q), 0);
      chk("R5 gbase after 5", int'(gr_base_q), 27);
      chk("R5 pbase after 5", int'(pr_base_q), 43);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule